// File: doc/BRIEF.md
# CEC Receive Frame Pool with Arrival Ordering

This block sits behind a bit-level CEC receiver and parks completed frames until a host drains them. It owns three frame buffers of up to sixteen bytes each. A frame arrives as a byte stream framed by a start strobe and an end strobe. It lands in the lowest-numbered free buffer. Each buffer reports a 5-bit stored length and a level ready interrupt.

To let the host drain frames oldest first, every buffer carries a 2-bit arrival rank. The three ranks are packed into one status word. The ranks stay dense and distinct while buffers fill and are released in any order. A host frees a buffer by raising and then lowering its release bit. Raising all three release bits together empties the pool. A mode input limits the pool to buffer 0 alone.

Top module: `cec_rx_pool`

## Requirements
- R1: After reset, the status word, all lengths, all ready interrupts and the overflow flag are zero.
- R2: On the end strobe of a frame with at least one byte, the frame goes into the lowest-numbered empty buffer that the mode allows. Its bytes can be read at indices 0 upward, and its byte count appears in that buffer's 5-bit length field (buffer k at `rx_len[5k+4:5k]`).
- R3: The status word holds buffer k's rank in bits [2k+1:2k]. Code 0 means empty, 1 means oldest, 2 second oldest and 3 third oldest. A newly stored frame takes a rank equal to the number of occupied buffers after it is stored, and occupied buffers never share a rank.
- R4: A rising edge on release bit k empties buffer k. Every occupied buffer whose rank was above the released rank drops by one. A rising edge for an empty buffer changes nothing.
- R5: Ready interrupt bit k is high from the cycle after buffer k is filled until it is released.
- R6: With `multi_mode` low, only buffer 0 is allocated. A frame that starts while buffer 0 is occupied is dropped and sets the overflow flag.
- R7: A frame that starts with no allowed empty buffer is dropped without changing any stored byte, length or rank. It sets the overflow flag, which stays high until a clear-all.
- R8: Bytes after the sixteenth of a frame are dropped, and the stored length saturates at 16.
- R9: Rising edges on all three release bits in the same cycle empty every buffer and clear the overflow flag.
- R10: A frame whose end strobe comes with no byte received is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | Frame start strobe |
| rx_byte_vld | input | 1 | Byte valid strobe |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | Frame end strobe; a byte valid in the same cycle is included |
| multi_mode | input | 1 | 1: all three buffers used; 0: buffer 0 only |
| rel_bits | input | 3 | Per-buffer release bits, acting on rising edges |
| rd_buf | input | 2 | Buffer selected for reading |
| rd_idx | input | 4 | Byte index selected for reading |
| rd_data | output | 8 | Selected byte, combinational |
| rx_len | output | 15 | Three packed 5-bit lengths |
| rx_status | output | 6 | Three packed 2-bit arrival ranks |
| rdy_irq | output | 3 | Per-buffer ready interrupts |
| rx_overflow | output | 1 | Sticky dropped-frame flag |

## Verification
Ranks, lengths, ready bits and the overflow flag are registered at the same clock edge that samples the end strobe, start strobe or release edge that causes them. The release edge is detected in the cycle the bit first reads high. The bench drives inputs on falling edges and samples one falling edge after the causing rising edge. Read data is combinational, so it is sampled half a cycle after the address changes. Release pulses are held high for one full cycle and then lowered before any result is checked.

// File: rtl/cec_rx_pool.sv
module cec_rx_pool #(
  parameter int MAX_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_start,
  input  logic        rx_byte_vld,
  input  logic [7:0]  rx_byte,
  input  logic        rx_end,
  input  logic        multi_mode,
  input  logic [2:0]  rel_bits,
  input  logic [1:0]  rd_buf,
  input  logic [3:0]  rd_idx,
  output logic [7:0]  rd_data,
  output logic [14:0] rx_len,
  output logic [5:0]  rx_status,
  output logic [2:0]  rdy_irq,
  output logic        rx_overflow
);
  localparam int NB = 3;
  localparam int LW = $clog2(MAX_BYTES + 1);
  localparam int AW = $clog2(MAX_BYTES);

  logic [7:0]    mem [NB][MAX_BYTES];
  logic [1:0]    rank [NB];
  logic [1:0]    rank_nx [NB];
  logic [LW-1:0] len [NB];
  logic [2:0]    rel_q, occ, keep, free;
  logic          cap;
  logic [1:0]    tgt, pick, dec;
  logic [LW-1:0] cnt, cnt_nx;
  logic          take, commit;

  wire [2:0] rel_rise = rel_bits & ~rel_q;
  wire       clr_all  = &rel_rise;

  assign take   = cap && rx_byte_vld && (cnt < LW'(MAX_BYTES));
  assign cnt_nx = cnt + LW'(take);
  assign commit = cap && rx_end && (cnt_nx != '0);
  assign free   = ~occ & (multi_mode ? 3'b111 : 3'b001);
  assign pick   = free[0] ? 2'd0 : (free[1] ? 2'd1 : 2'd2);

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      occ[i]  = rank[i] != 2'd0;
      keep[i] = occ[i] && !rel_rise[i];
    end
    for (int i = 0; i < NB; i++) begin
      dec = 2'd0;
      for (int j = 0; j < NB; j++)
        if (rel_rise[j] && occ[j] && rank[j] < rank[i]) dec = dec + 2'd1;
      rank_nx[i] = keep[i] ? rank[i] - dec : 2'd0;
    end
    if (commit) rank_nx[tgt] = 2'($countones(keep)) + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_q       <= '0;
      cap         <= 1'b0;
      tgt         <= '0;
      cnt         <= '0;
      rx_overflow <= 1'b0;
      for (int i = 0; i < NB; i++) begin
        rank[i] <= '0;
        len[i]  <= '0;
      end
    end else begin
      rel_q <= rel_bits;
      for (int i = 0; i < NB; i++) rank[i] <= rank_nx[i];
      rx_overflow <= (rx_overflow && !clr_all) || (rx_start && free == 3'b000);
      if (rx_start) begin
        cap <= free != 3'b000;
        tgt <= pick;
        cnt <= '0;
      end else if (cap) begin
        cnt <= cnt_nx;
        if (rx_end) cap <= 1'b0;
        if (commit) len[tgt] <= cnt_nx;
      end
    end
  end

  always_ff @(posedge clk)
    if (take && !rx_start) mem[tgt][cnt[AW-1:0]] <= rx_byte;

  assign rd_data   = (rd_buf < 2'd3) ? mem[rd_buf][rd_idx[AW-1:0]] : 8'h00;
  assign rx_status = {rank[2], rank[1], rank[0]};
  assign rx_len    = {5'(len[2]), 5'(len[1]), 5'(len[0])};
  assign rdy_irq   = occ;
endmodule

module cec_rx_pool_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  status,
  input logic [14:0] lens,
  input logic [2:0]  rel_rise,
  input logic        ovf
);
  logic [1:0] r0, r1, r2;
  assign r0 = status[1:0];
  assign r1 = status[3:2];
  assign r2 = status[5:4];
  wire [1:0] nocc = 2'((r0 != 0) + (r1 != 0)) + 2'(r2 != 0);

  p_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !((r0 != 0 && r0 == r1) || (r0 != 0 && r0 == r2) || (r1 != 0 && r1 == r2)));
  p_rank_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    r0 <= nocc && r1 <= nocc && r2 <= nocc);
  p_len_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lens[4:0] <= 5'd16 && lens[9:5] <= 5'd16 && lens[14:10] <= 5'd16);
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(&rel_rise) |=> ovf);

  for (genvar k = 0; k < 3; k++) begin : g_rel
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rel_rise[k] && status[2*k +: 2] != 2'd0 |=> status[2*k +: 2] == 2'd0);
  end
endmodule

bind cec_rx_pool cec_rx_pool_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status(rx_status), .lens(rx_len),
  .rel_rise(rel_rise), .ovf(rx_overflow)
);

// File: tb/test_cec_rx_pool.sv
module test_cec_rx_pool;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_start = 0, rx_byte_vld = 0, rx_end = 0, multi_mode = 1;
  logic [7:0] rx_byte = 0;
  logic [2:0] rel_bits = 0;
  logic [1:0] rd_buf = 0;
  logic [3:0] rd_idx = 0;
  logic [7:0] rd_data;
  logic [14:0] rx_len;
  logic [5:0] rx_status;
  logic [2:0] rdy_irq;
  logic rx_overflow;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cec_rx_pool i_cec_rx_pool (.*);

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(int n, int base);
    @(negedge clk) rx_start = 1;
    @(negedge clk) rx_start = 0;
    for (int i = 0; i < n; i++) begin
      rx_byte_vld = 1; rx_byte = 8'(base + i);
      @(negedge clk);
    end
    rx_byte_vld = 0; rx_end = 1;
    @(negedge clk) rx_end = 0;
  endtask

  task automatic release_buf(logic [2:0] m);
    @(negedge clk) rel_bits = m;
    @(negedge clk) rel_bits = 0;
    @(negedge clk);
  endtask

  task automatic rd(int b, int i, output int v);
    rd_buf = 2'(b); rd_idx = 4'(i);
    #1 v = rd_data;
  endtask

  task automatic t_reset;
    chk("R1 status", rx_status, 0);
    chk("R1 len", rx_len, 0);
    chk("R1 irq", rdy_irq, 0);
    chk("R1 ovf", rx_overflow, 0);
  endtask

  task automatic t_fill;
    int v;
    send(3, 8'h10); send(16, 8'h40); send(2, 8'hA0);
    chk("R3 status", rx_status, 6'h39);
    chk("R2 len0", rx_len[4:0], 3);
    chk("R2 len1", rx_len[9:5], 16);
    chk("R2 len2", rx_len[14:10], 2);
    chk("R5 irq", rdy_irq, 3'b111);
    rd(0, 2, v); chk("R2 byte0.2", v, 8'h12);
    rd(1, 15, v); chk("R2 byte1.15", v, 8'h4F);
    rd(2, 1, v); chk("R2 byte2.1", v, 8'hA1);
  endtask

  task automatic t_overflow;
    int v;
    send(4, 8'hE0);
    chk("R7 status", rx_status, 6'h39);
    chk("R7 ovf", rx_overflow, 1);
    chk("R7 len0", rx_len[4:0], 3);
    rd(0, 0, v); chk("R7 byte0.0", v, 8'h10);
  endtask

  task automatic t_release_mid;
    release_buf(3'b010);
    chk("R4 status", rx_status, 6'h21);
    chk("R5 irq", rdy_irq, 3'b101);
    chk("R7 sticky", rx_overflow, 1);
    release_buf(3'b010);
    chk("R4 empty rel", rx_status, 6'h21);
  endtask

  task automatic t_refill;
    int v;
    send(5, 8'h60);
    chk("R2 R3 refill", rx_status, 6'h2D);
    chk("R2 len1", rx_len[9:5], 5);
    rd(1, 4, v); chk("R2 byte1.4", v, 8'h64);
    release_buf(3'b001);
    chk("R4 oldest", rx_status, 6'h18);
  endtask

  task automatic t_trunc;
    int v;
    send(20, 8'h80);
    chk("R8 status", rx_status, 6'h1B);
    chk("R8 len", rx_len[4:0], 16);
    rd(0, 15, v); chk("R8 last", v, 8'h8F);
  endtask

  task automatic t_clear_all;
    release_buf(3'b111);
    chk("R9 status", rx_status, 0);
    chk("R9 irq", rdy_irq, 0);
    chk("R9 ovf", rx_overflow, 0);
  endtask

  task automatic t_zero;
    send(0, 0);
    chk("R10 status", rx_status, 0);
  endtask

  task automatic t_single;
    multi_mode = 0;
    send(2, 8'h30);
    chk("R6 first", rx_status, 6'h01);
    send(2, 8'h50);
    chk("R6 drop", rx_status, 6'h01);
    chk("R6 ovf", rx_overflow, 1);
    release_buf(3'b111);
    multi_mode = 1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset; t_fill; t_overflow; t_release_mid; t_refill;
        t_trunc; t_clear_all; t_zero; t_single;
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule